// File: doc/BRIEF.md
# Interrupt Pending, Mask and Force Register Bank

This block holds the interrupt bookkeeping for a group of independent sources. Each source has a sticky pending bit, a mask bit and an output pin. A one-cycle hardware pulse on a source's event line latches its pending bit. Software then acknowledges the interrupt by writing ones to the pending register. Software can also raise pending bits on purpose through a force register. This register only accepts writes, so driver code and fault paths can be tested without real hardware events. An output pin is high while its source is both pending and unmasked.

Software reaches the bank through a simple single-cycle register port: a write strobe, a two-bit register select, write data and read data. Read data depends only on the select and the stored state, with no read strobe. Bus decoding, priority selection and routing to a core belong to the surrounding logic.

Register select codes: 0 is the pending register, 1 is the mask register, 2 is the force register, and 3 is unassigned. In every register, bit i belongs to source i.

Top module: `irq_bank`

## Requirements
- R1: After reset, the pending register reads 0, the mask register reads 0 and every output pin is low.
- R2: A write with select 1 loads the mask register. A read with select 1 returns the value last written.
- R3: A write with select 0 clears each pending bit whose write-data bit is 1 and leaves the other pending bits unchanged.
- R4: A write with select 2 sets each pending bit whose write-data bit is 1. If pending starts at zero, a read with select 0 then returns exactly the value written.
- R5: A read with select 2 always returns 0.
- R6: A one-cycle pulse on event bit i sets pending bit i. The bit stays set, with no further pulses, until software clears it.
- R7: If an event pulse on bit i and a pending-clear write of bit i arrive in the same cycle, pending bit i ends set.
- R8: Output pin i is high exactly when pending bit i and mask bit i are both 1. If a bit is already pending and its mask bit is then written to 1, the pin rises right after that write's clock edge.
- R9: Select 3 reads as 0. A write with select 3 changes neither the pending register nor the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| reg_we_i | input | 1 | Register write strobe, sampled on the rising edge |
| reg_sel_i | input | 2 | Register select (0 pending, 1 mask, 2 force, 3 unassigned) |
| reg_wdata_i | input | NUM_SRC | Write data, bit i for source i |
| reg_rdata_o | output | NUM_SRC | Read data for the selected register |
| hw_event_i | input | NUM_SRC | Per-source event pulses |
| irq_o | output | NUM_SRC | Per-source interrupt pins |

## Verification
Every write and event pulse takes effect at the next rising edge. The new pending and mask values, and the pins derived from them, appear in the same cycle, one register after the stimulus. Read data follows the select with no clock in between, so a read check drives the select and samples it a short time later with no edge in between. The bench drives inputs on falling edges and compares against its model on the following falling edge, which is exactly one register stage later.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_PEND  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_FORCE = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic pend;
        logic mask;
    } cell_state_t;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_bank_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               we_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [NUM_SRC-1:0] force_o,
    output logic               mask_we_o,
    output logic [NUM_SRC-1:0] rdata_o
);

    reg_sel_e sel;

    always_comb begin
        sel       = reg_sel_e'(sel_i);
        clr_o     = '0;
        force_o   = '0;
        mask_we_o = 1'b0;
        rdata_o   = '0;
        unique case (sel)
            SEL_PEND: begin
                rdata_o = pend_i;
                if (we_i) clr_o = wdata_i;
            end
            SEL_MASK: begin
                rdata_o = mask_i;
                mask_we_o = we_i;
            end
            SEL_FORCE: begin
                if (we_i) force_o = wdata_i;
            end
            default: begin
                rdata_o = '0;
            end
        endcase
    end

    // R9: at most one register takes a write in any cycle
    a_r9_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({|clr_o, |force_o, mask_we_o}));

    // R5: the force register never reads back
    a_r5_force_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SEL_FORCE) |-> (rdata_o == '0));

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_bank_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hw_set_i,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    input  logic mask_we_i,
    input  logic mask_wbit_i,
    output logic pend_o,
    output logic mask_o,
    output logic irq_o
);

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_clr_i) st_d.pend = 1'b0;
        if (hw_set_i || sw_set_i) st_d.pend = 1'b1;
        if (mask_we_i) st_d.mask = mask_wbit_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
    assign irq_o  = st_q.pend & st_q.mask;

    a_r6_event_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_set_i |=> pend_o);

    a_r6_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o && !sw_clr_i) |=> pend_o);

    a_r7_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_set_i && sw_clr_i) |=> pend_o);

    a_r3_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_clr_i && !hw_set_i && !sw_set_i) |=> !pend_o);

    a_r4_force_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_set_i |=> pend_o);

    a_r2_mask_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_we_i |=> (mask_o == $past(mask_wbit_i)));

    a_r8_pin_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (pend_o && mask_o));

endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               reg_we_i,
    input  logic [1:0]         reg_sel_i,
    input  logic [NUM_SRC-1:0] reg_wdata_i,
    output logic [NUM_SRC-1:0] reg_rdata_o,
    input  logic [NUM_SRC-1:0] hw_event_i,
    output logic [NUM_SRC-1:0] irq_o
);

    logic [NUM_SRC-1:0] pend_vec, mask_vec, clr_vec, force_vec;
    logic               mask_we;

    irq_reg_decode #(.NUM_SRC(NUM_SRC)) u_decode (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (reg_we_i),
        .sel_i     (reg_sel_i),
        .wdata_i   (reg_wdata_i),
        .pend_i    (pend_vec),
        .mask_i    (mask_vec),
        .clr_o     (clr_vec),
        .force_o   (force_vec),
        .mask_we_o (mask_we),
        .rdata_o   (reg_rdata_o)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_src_cell u_cell (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .hw_set_i    (hw_event_i[i]),
            .sw_set_i    (force_vec[i]),
            .sw_clr_i    (clr_vec[i]),
            .mask_we_i   (mask_we),
            .mask_wbit_i (reg_wdata_i[i]),
            .pend_o      (pend_vec[i]),
            .mask_o      (mask_vec[i]),
            .irq_o       (irq_o[i])
        );
    end

    // R9: writes to the unassigned select leave both registers alone
    a_r9_unassigned_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_sel_i == 2'd3 && hw_event_i == '0) |=>
            ($stable(pend_vec) && $stable(mask_vec)));

endmodule

// File: tb/irq_bank_bench.sv
module irq_bank_bench;

    localparam int N = 8;
    localparam time CYC = 20ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         we = 1'b0;
    logic [1:0]   sel = 2'd0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] ev = '0;
    logic [N-1:0] rdata, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [N-1:0] m_pend, m_mask;

    always #(CYC/2) clk = ~clk;

    irq_bank #(.NUM_SRC(N)) u_irq_bank (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_we_i    (we),
        .reg_sel_i   (sel),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .hw_event_i  (ev),
        .irq_o       (irq)
    );

    // Behavioural model: what software and events should leave behind each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend <= '0;
            m_mask <= '0;
        end else begin
            logic [N-1:0] nxt;
            nxt = m_pend;
            if (we && sel == 2'd0) nxt = nxt & ~wdata;
            if (we && sel == 2'd2) nxt = nxt | wdata;
            nxt = nxt | ev;
            m_pend <= nxt;
            if (we && sel == 2'd1) m_mask <= wdata;
        end
    end

    function automatic logic [N-1:0] model_read(input logic [1:0] s);
        case (s)
            2'd0:    return m_pend;
            2'd1:    return m_mask;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare against the model, then drive new inputs on the falling edge
    task automatic step(input string tag, input logic w, input logic [1:0] s,
                        input logic [N-1:0] d, input logic [N-1:0] e);
        @(negedge clk);
        #1;
        check({tag, " pins"}, irq, m_pend & m_mask);
        check({tag, " rdata"}, rdata, model_read(sel));
        we = w; sel = s; wdata = d; ev = e;
    endtask

    task automatic rd(input string tag, input logic [1:0] s, input logic [N-1:0] exp);
        step(tag, 1'b0, s, '0, '0);
        #1;
        check(tag, rdata, exp);
    endtask

    initial begin
        #(CYC * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd("R1 pending", 2'd0, 8'h00);
        rd("R1 mask", 2'd1, 8'h00);
        check("R1 pins", irq, 8'h00);
        // R2: mask read/write
        step("R2", 1'b1, 2'd1, 8'hA5, '0);
        rd("R2 mask", 2'd1, 8'hA5);
        // R4: force from zero reads back
        step("R4", 1'b1, 2'd2, 8'h3C, '0);
        rd("R4 pending", 2'd0, 8'h3C);
        check("R8 pins", irq, 8'h24);
        // R5: force reads zero
        rd("R5 force", 2'd2, 8'h00);
        // R3: write-one clear
        step("R3", 1'b1, 2'd0, 8'h0C, '0);
        rd("R3 pending", 2'd0, 8'h30);
        // R6: single event pulse sticks
        step("R6", 1'b0, 2'd0, '0, 8'h01);
        step("R6 idle", 1'b0, 2'd0, '0, '0);
        repeat (4) step("R6 idle", 1'b0, 2'd0, '0, '0);
        rd("R6 pending", 2'd0, 8'h31);
        // R7: event and clear on the same bit
        step("R7", 1'b1, 2'd0, 8'h11, 8'h01);
        rd("R7 pending", 2'd0, 8'h21);
        // R8: pending while masked, then unmask
        step("R8", 1'b1, 2'd2, 8'h02, '0);
        rd("R8 pending", 2'd0, 8'h23);
        check("R8 masked pin", irq, 8'h21);
        step("R8 unmask", 1'b1, 2'd1, 8'hA7, '0);
        step("R8 after", 1'b0, 2'd1, '0, '0);
        check("R8 unmasked pin", irq, 8'h23);
        // R9: unassigned select
        step("R9", 1'b1, 2'd3, 8'hFF, '0);
        rd("R9 read", 2'd3, 8'h00);
        rd("R9 pending", 2'd0, 8'h23);
        rd("R9 mask", 2'd1, 8'hA7);
        // Mixed traffic against the model
        for (int k = 0; k < 400; k++) begin
            logic [N-1:0] evr;
            evr = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
            step("R3 R4 R6 R7 R8 mixed", 1'($urandom), 2'($urandom), N'($urandom), evr);
        end
        step("R1 final", 1'b0, 2'd0, '0, '0);
        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd("R1 again pending", 2'd0, 8'h00);
        rd("R1 again mask", 2'd1, 8'h00);
        check("R1 again pins", irq, 8'h00);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule